// File: doc/BRIEF.md
# Double-Buffered Streaming Template Matcher

The block takes a byte stream that arrives at a modest rate and writes it into one half of a two-bank buffer. The other half, filled earlier, is scanned against a small store of templates. Each scan pass reads the scanned bank one byte per clock through a shift window as wide as a template. Once the window holds a full template's worth of bytes, it compares them with the current template and reports every offset where all bytes agree. The templates are scanned one after another, from index zero upwards, within a single fill period. When the filling bank receives its last byte, the banks change roles and the scan starts over on the bank that has just been completed.

Templates are written as a whole through a wide port, one slot per write. The ratio between the core clock and the input byte rate is set by the gaps between valid input bytes. If the input fills a bank before all templates have been scanned, the banks still change roles. A one-cycle overrun flag then marks that the templates left over for the older bank were skipped. Each result carries the match offset, the template index and the sequence number of the bank fill it belongs to.

Top module: `tm_matcher`

## Requirements
- R1: While reset is high and in the first cycle after it, `m_valid` and `overrun` are low.
- R2: A byte is written into the filling bank only in a cycle with `in_valid` high. Bytes presented while `in_valid` is low never appear in the data that is scanned.
- R3: Once `BUF_BYTES` valid bytes have been taken into a bank, that bank is scanned. Its results carry `m_seq`, which is 0 for the first completed fill and then grows by one for each fill.
- R4: A match at offset p for template t is reported when byte k of the template (bits 8k+7..8k of the slot) equals buffered byte p+k for every k below `TPL_LEN`. `m_pos` is p and `m_tpl` is t.
- R5: Offsets above `BUF_BYTES-TPL_LEN` are never reported, so a pattern that runs across the boundary between two fills does not match. The last offset, `BUF_BYTES-TPL_LEN`, is reported.
- R6: Within one fill, templates are scanned in ascending index order and offsets in ascending order for each template. Each template is scanned once per fill.
- R7: A write with `tpl_we` high stores `tpl_data` into slot `tpl_idx` at that clock edge. Scans that start afterwards use the new value.
- R8: If a bank fills while a scan is still in progress, `overrun` is high for exactly the one cycle after the edge that took the last byte. The remaining templates of the older bank are skipped, and the new bank is scanned from template 0 with its complete result set.
- R9: If each scan finishes before the next bank fills, `overrun` stays low.
- R10: `m_valid` is a registered single-cycle strobe per result, and it is low whenever no scan is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Input stream byte |
| tpl_we | input | 1 | Template slot write enable |
| tpl_idx | input | TW | Template slot written |
| tpl_data | input | TPL_LEN*8 | Template bytes, byte k in bits 8k+7..8k |
| m_valid | output | 1 | Match result strobe |
| m_pos | output | AW | Offset of the match in its fill |
| m_tpl | output | TW | Index of the matching template |
| m_seq | output | SEQ_W | Fill sequence number of the scanned bank |
| overrun | output | 1 | Scan cut short by a bank swap |

## Verification
The swap happens at the edge that takes the last byte of a fill. `overrun` is therefore due exactly one cycle later, and the bench samples it on the falling edge that follows that edge and again one cycle after that. A match for template t at offset p is registered `t*BUF_BYTES + p + TPL_LEN + 1` cycles after the swap edge. The bench collects results on falling edges and compares the whole ordered list against a model of the buffer contents. That model is recorded as each fill completes, and the bench waits well beyond the full scan time before it compares. Garbage bytes are driven during input gaps, and one template is made of those garbage bytes, so any byte stored without `in_valid` would show up as a match.

// File: rtl/tm_pkg.sv
package tm_pkg;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/tm_pp_mem.sv
// Two-bank byte memory: one write port for the filling bank, one registered
// read port for the scanned bank (block RAM friendly).
module tm_pp_mem #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic            wbank,
  input  logic [AW-1:0]   waddr,
  input  tm_pkg::byte_t   wdata,
  input  logic            rbank,
  input  logic [AW-1:0]   raddr,
  output tm_pkg::byte_t   rdata
);
  tm_pkg::byte_t mem [2*DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{wbank, waddr}] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[{rbank, raddr}];
  end
endmodule

// File: rtl/tm_tpl_store.sv
// Template slots, written whole through a wide port.
module tm_tpl_store #(
  parameter int NUM_TPL = 4,
  parameter int TPL_LEN = 8,
  localparam int TW = (NUM_TPL > 1) ? $clog2(NUM_TPL) : 1,
  localparam int W  = TPL_LEN * 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [TW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [TW-1:0] ridx,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] slot [NUM_TPL];

  for (genvar g = 0; g < NUM_TPL; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slot[g] <= '0;
      else if (we && widx == TW'(g)) slot[g] <= wdata;
    end
  end

  assign rdata = slot[ridx];
endmodule

// File: rtl/tm_scanner.sv
// Walks every template across the scanned bank, one byte per clock,
// through a shift window, and registers one result per matching offset.
module tm_scanner #(
  parameter int BUF_BYTES = 1024,
  parameter int TPL_LEN   = 8,
  parameter int NUM_TPL   = 4,
  parameter int SEQ_W     = 8,
  localparam int AW = $clog2(BUF_BYTES),
  localparam int TW = (NUM_TPL > 1) ? $clog2(NUM_TPL) : 1,
  localparam int W  = TPL_LEN * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SEQ_W-1:0] start_seq,
  output logic [AW-1:0]    rd_addr,
  input  tm_pkg::byte_t    rdata,
  output logic [TW-1:0]    tpl_sel,
  input  logic [W-1:0]     tpl,
  output logic             busy,
  output logic             m_valid,
  output logic [AW-1:0]    m_pos,
  output logic [TW-1:0]    m_tpl,
  output logic [SEQ_W-1:0] m_seq
);
  logic             iss_act;
  logic [AW-1:0]    iss_addr;
  logic [TW-1:0]    iss_tpl;
  logic             p_vld;
  logic [AW-1:0]    p_addr;
  logic [TW-1:0]    p_tpl;
  logic [W-1:0]     win;
  logic [W-1:0]     nwin;
  logic [SEQ_W-1:0] scan_seq;
  logic             hit;

  assign rd_addr = iss_addr;
  assign tpl_sel = p_tpl;
  assign busy    = iss_act | p_vld;

  // newest byte enters at the top, so bits 7:0 hold the oldest byte (offset p)
  if (TPL_LEN > 1) begin : g_win
    assign nwin = {rdata, win[W-1:8]};
  end else begin : g_win1
    assign nwin = rdata;
  end
  assign hit = (nwin == tpl) && (p_addr >= AW'(TPL_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_act  <= 1'b0;
      iss_addr <= '0;
      iss_tpl  <= '0;
      p_vld    <= 1'b0;
      p_addr   <= '0;
      p_tpl    <= '0;
      win      <= '0;
      scan_seq <= '0;
      m_valid  <= 1'b0;
      m_pos    <= '0;
      m_tpl    <= '0;
      m_seq    <= '0;
    end else if (start) begin
      iss_act  <= 1'b1;
      iss_addr <= '0;
      iss_tpl  <= '0;
      p_vld    <= 1'b0;
      scan_seq <= start_seq;
      m_valid  <= 1'b0;
    end else begin
      p_vld  <= iss_act;
      p_addr <= iss_addr;
      p_tpl  <= iss_tpl;
      if (iss_act) begin
        if (iss_addr == AW'(BUF_BYTES - 1)) begin
          iss_addr <= '0;
          if (iss_tpl == TW'(NUM_TPL - 1)) iss_act <= 1'b0;
          else iss_tpl <= iss_tpl + 1'b1;
        end else begin
          iss_addr <= iss_addr + 1'b1;
        end
      end
      if (p_vld) begin
        win     <= nwin;
        m_valid <= hit;
        m_pos   <= p_addr - AW'(TPL_LEN - 1);
        m_tpl   <= p_tpl;
        m_seq   <= scan_seq;
      end else begin
        m_valid <= 1'b0;
      end
    end
  end

  // R5: reported offsets stay inside the bank
  a_r5_pos_in_range: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (m_pos <= AW'(BUF_BYTES - TPL_LEN)));

  // R6: consecutive results of one fill keep template-then-offset order
  a_r6_result_order: assert property (@(posedge clk) disable iff (rst)
    (m_valid && $past(m_valid) && m_seq == $past(m_seq)) |->
      ((m_tpl > $past(m_tpl)) || (m_tpl == $past(m_tpl) && m_pos > $past(m_pos))));

  // R10: no result strobe once the scan has drained
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !m_valid);
endmodule

// File: rtl/tm_matcher.sv
// Top: fill side, bank swap and overrun detection around the scanner.
module tm_matcher #(
  parameter int BUF_BYTES = 1024,
  parameter int TPL_LEN   = 8,
  parameter int NUM_TPL   = 4,
  parameter int SEQ_W     = 8,
  localparam int AW = $clog2(BUF_BYTES),
  localparam int TW = (NUM_TPL > 1) ? $clog2(NUM_TPL) : 1,
  localparam int W  = TPL_LEN * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             tpl_we,
  input  logic [TW-1:0]    tpl_idx,
  input  logic [W-1:0]     tpl_data,
  output logic             m_valid,
  output logic [AW-1:0]    m_pos,
  output logic [TW-1:0]    m_tpl,
  output logic [SEQ_W-1:0] m_seq,
  output logic             overrun
);
  logic             load_bank;
  logic [AW-1:0]    wr_ptr;
  logic [SEQ_W-1:0] fill_seq;
  logic             fill_done;
  logic             scan_busy;
  logic [AW-1:0]    rd_addr;
  tm_pkg::byte_t    rdata;
  logic [TW-1:0]    tpl_sel;
  logic [W-1:0]     tpl_cur;

  assign fill_done = in_valid && (wr_ptr == AW'(BUF_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      load_bank <= 1'b0;
      wr_ptr    <= '0;
      fill_seq  <= '0;
      overrun   <= 1'b0;
    end else begin
      overrun <= 1'b0;
      if (in_valid) wr_ptr <= fill_done ? '0 : wr_ptr + 1'b1;
      if (fill_done) begin
        load_bank <= ~load_bank;
        fill_seq  <= fill_seq + 1'b1;
        overrun   <= scan_busy;
      end
    end
  end

  tm_pp_mem #(.DEPTH(BUF_BYTES)) u_mem (
    .clk   (clk),
    .we    (in_valid),
    .wbank (load_bank),
    .waddr (wr_ptr),
    .wdata (in_byte),
    .rbank (~load_bank),
    .raddr (rd_addr),
    .rdata (rdata)
  );

  tm_tpl_store #(.NUM_TPL(NUM_TPL), .TPL_LEN(TPL_LEN)) u_tpl (
    .clk   (clk),
    .rst   (rst),
    .we    (tpl_we),
    .widx  (tpl_idx),
    .wdata (tpl_data),
    .ridx  (tpl_sel),
    .rdata (tpl_cur)
  );

  tm_scanner #(
    .BUF_BYTES(BUF_BYTES), .TPL_LEN(TPL_LEN),
    .NUM_TPL(NUM_TPL), .SEQ_W(SEQ_W)
  ) u_scan (
    .clk       (clk),
    .rst       (rst),
    .start     (fill_done),
    .start_seq (fill_seq),
    .rd_addr   (rd_addr),
    .rdata     (rdata),
    .tpl_sel   (tpl_sel),
    .tpl       (tpl_cur),
    .busy      (scan_busy),
    .m_valid   (m_valid),
    .m_pos     (m_pos),
    .m_tpl     (m_tpl),
    .m_seq     (m_seq)
  );

  // R2: the fill pointer only moves on a valid byte
  a_r2_ptr_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(wr_ptr));

  // R8: overrun is a single-cycle pulse
  a_r8_ovr_pulse: assert property (@(posedge clk) disable iff (rst)
    overrun |=> !overrun);

  // R8: overrun only follows a cycle that took an input byte
  a_r8_ovr_after_byte: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(in_valid));
endmodule

// File: tb/tm_matcher_tb.sv
module tm_matcher_tb;
  localparam int BUF = 32;
  localparam int L   = 4;
  localparam int NT  = 3;
  localparam int SW  = 8;
  localparam int AW  = $clog2(BUF);
  localparam int TW  = 2;
  localparam int NV  = 5;
  // {seed[7:0], gap[3:0], mode[3:0]}
  localparam logic [15:0] VEC [NV] = '{16'h1330, 16'h2741, 16'h0532, 16'h3A51, 16'hC130};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic tpl_we = 1'b0;
  logic [TW-1:0] tpl_idx = '0;
  logic [L*8-1:0] tpl_data = '0;
  logic m_valid;
  logic [AW-1:0] m_pos;
  logic [TW-1:0] m_tpl;
  logic [SW-1:0] m_seq;
  logic overrun;

  always #4 clk = ~clk;

  tm_matcher #(.BUF_BYTES(BUF), .TPL_LEN(L), .NUM_TPL(NT), .SEQ_W(SW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .tpl_we(tpl_we), .tpl_idx(tpl_idx), .tpl_data(tpl_data),
    .m_valid(m_valid), .m_pos(m_pos), .m_tpl(m_tpl), .m_seq(m_seq),
    .overrun(overrun)
  );

  int n_chk = 0;
  int n_bad = 0;
  int fill_cnt = 0;
  int ovr_cnt = 0;
  int got_n = 0;
  int exp_n = 0;
  int got_seq [1024];
  int got_tpl [1024];
  int got_pos [1024];
  int exp_seq [512];
  int exp_tpl [512];
  int exp_pos [512];
  logic [L*8-1:0] tb_tpl [NT];
  logic [7:0] cur [BUF];
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (m_valid && got_n < 1024) begin
        got_seq[got_n] = int'(m_seq);
        got_tpl[got_n] = int'(m_tpl);
        got_pos[got_n] = int'(m_pos);
        got_n++;
      end
      if (overrun) ovr_cnt++;
    end
  end

  task automatic load_tpl(input int idx, input logic [L*8-1:0] d);
    @(negedge clk);
    tpl_we = 1'b1; tpl_idx = TW'(idx); tpl_data = d;
    tb_tpl[idx] = d;
    @(negedge clk);
    tpl_we = 1'b0;
  endtask

  // R4 model: expected matches of the current contents, taken at fill end
  task automatic model(input int seq);
    for (int t = 0; t < NT; t++) begin
      for (int p = 0; p <= BUF - L; p++) begin
        bit m = 1'b1;
        for (int k = 0; k < L; k++)
          if (cur[p+k] != tb_tpl[t][8*k +: 8]) m = 1'b0;
        if (m) begin
          exp_seq[exp_n] = seq; exp_tpl[exp_n] = t; exp_pos[exp_n] = p;
          exp_n++;
        end
      end
    end
  endtask

  task automatic fill(input logic [7:0] seed, input int gap, input int mode, input bit rec);
    for (int i = 0; i < BUF; i++) cur[i] = 8'((int'(seed) * (i + 1) ^ (i >> 2)) & 3);
    if (mode == 1) begin
      for (int k = 0; k < L; k++) begin cur[k] = 8'(k); cur[BUF-L+k] = 8'(k); end
    end else if (mode == 2) begin
      for (int k = 0; k < L - 1; k++) cur[BUF-L+1+k] = 8'(k);
      for (int k = 0; k < L; k++) cur[10+k] = 8'd2;
    end
    for (int i = 0; i < BUF; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_byte = cur[i];
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0; in_byte = 8'hAA;
      end
    end
    if (rec) model(fill_cnt);
    fill_cnt++;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cut_seq;
    int j;
    bit seen_last;
    int bad_cnt;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(m_valid == 1'b0 && overrun == 1'b0, "R1 during reset", int'(m_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(m_valid == 1'b0 && overrun == 1'b0, "R1 after reset", int'(overrun), 0);

    // R7: template slots via the wide port
    load_tpl(0, 32'h03020100);
    load_tpl(1, 32'hAAAAAAAA);
    load_tpl(2, 32'h02020202);

    // table of fills with gaps (garbage 0xAA driven while in_valid is low)
    for (int v = 0; v < NV; v++)
      fill(VEC[v][15:8], int'(VEC[v][7:4]), int'(VEC[v][3:0]), 1'b1);
    in_valid = 1'b0;
    repeat (120) @(negedge clk);
    check(ovr_cnt == 0, "R9 no overrun with slow input", ovr_cnt, 0);

    // R7: rewrite slot 2, then two back-to-back fills to force an overrun (R8)
    load_tpl(2, 32'h03010301);
    cut_seq = fill_cnt;
    fill(8'h5D, 0, 1, 1'b0);
    check(ovr_cnt == 0, "R9 swap onto idle scanner", ovr_cnt, 0);
    fill(8'h6B, 0, 2, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    check(overrun == 1'b1, "R8 overrun one cycle after fill", int'(overrun), 1);
    @(negedge clk);
    check(overrun == 1'b0, "R8 overrun single pulse", int'(overrun), 0);
    repeat (150) @(negedge clk);
    check(ovr_cnt == 1, "R8 overrun count", ovr_cnt, 1);

    // R8: the cut scan only reached template 0
    bad_cnt = 0;
    for (int i = 0; i < got_n; i++)
      if (got_seq[i] == cut_seq && got_tpl[i] != 0) bad_cnt++;
    check(bad_cnt == 0, "R8 skipped templates not reported", bad_cnt, 0);

    // R2: no match of the garbage template
    bad_cnt = 0;
    for (int i = 0; i < got_n; i++) if (got_tpl[i] == 1) bad_cnt++;
    check(bad_cnt == 0, "R2 gap bytes not stored", bad_cnt, 0);

    // R5: no offset past the end; last offset reported (fill seq 1, mode 1)
    bad_cnt = 0;
    seen_last = 1'b0;
    for (int i = 0; i < got_n; i++) begin
      if (got_pos[i] > BUF - L) bad_cnt++;
      if (got_seq[i] == 1 && got_tpl[i] == 0 && got_pos[i] == BUF - L) seen_last = 1'b1;
    end
    check(bad_cnt == 0, "R5 offsets in range", bad_cnt, 0);
    check(seen_last, "R5 last offset reported", int'(seen_last), 1);

    // R3/R4/R6/R7: full ordered result list against the model
    j = 0;
    for (int i = 0; i < got_n; i++) begin
      if (got_seq[i] == cut_seq) continue;
      if (j < exp_n)
        check(got_seq[i] == exp_seq[j] && got_tpl[i] == exp_tpl[j] && got_pos[i] == exp_pos[j],
              "R4 R6 R7 result entry (seq*4096+tpl*256+pos)",
              got_seq[i] * 4096 + got_tpl[i] * 256 + got_pos[i],
              exp_seq[j] * 4096 + exp_tpl[j] * 256 + exp_pos[j]);
      j++;
    end
    check(j == exp_n, "R3 result count per completed fill", j, exp_n);
    check(exp_n > 0 && got_n > 0 && got_seq[0] == 0, "R3 first fill seq 0", got_seq[0], 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule